// File: doc/BRIEF.md
# Four-Channel PWM Controller with Commit-Gated Reload

This block generates four independent, active-high pulse-width-modulated outputs. Each channel is programmed through a small 32-bit register bus: a tick divider (prescale), a period length in ticks (modulus), a high-time length in ticks (duty) and a run bit. The bus is a plain address, write strobe, write data and registered read data interface. Each channel occupies its own 32-byte window.

Prescale and modulus writes only land in a staging set. Writing the duty register stages the duty value and also arms a commit. A channel that is running copies the whole staged set into its working set at the end of the period in progress, so a period is never built from a mix of old and new settings. A channel that is stopped takes an armed commit on the next cycle. Clearing the run bit stops a channel and forces its output low without waiting for the period to finish.

Top module: `pwm_ctrl_top`

## Requirements
- R1: A bus address selects channel `addr[6:5]` and register `addr[4:0]`. The register offsets are 0x00 for prescale, 0x04 for modulus, 0x08 for duty and 0x18 for the run bit.
- R2: Read data is registered and appears one cycle after the address. Prescale (8 bits), modulus (8 bits) and duty (16 bits) read back the last written value, zero-extended. The run register returns the run state in bit 0. Upper write-data bits are discarded.
- R3: Any other offset inside a window reads as zero, and writes to it change nothing.
- R4: One tick lasts prescale+1 clock cycles. A period lasts max(modulus,1) ticks. The output is high during the first duty ticks of each period. A duty of 0 gives a constant low output, and a duty at or above the modulus gives a constant high output.
- R5: Writing prescale or modulus alone never changes the waveform.
- R6: A duty write arms a commit. A running channel loads the staged prescale, modulus and duty together at the end of its current period.
- R7: Writing 0 to the run bit forces the output low one cycle after the write edge, in mid-period if needed.
- R8: A stopped channel with an armed commit loads it on the next cycle. Writing 1 to the run bit starts a fresh period from tick 0, and the output rises one cycle after the write edge when duty is nonzero.
- R9: A synchronous active-high reset clears every register, working value and counter, stops all channels and drives the outputs and read data to zero.
- R10: The channels are independent. Writes to one channel never alter another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address: channel in [6:5], register offset in [4:0] |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address presented in the previous cycle |
| pwm_out | output | 4 | One active-high PWM output per channel |

## Verification
A tick or step counter that holds a wrong value shows up at the pin as a high time or period that is too long or too short. That error is visible within one period of the channel concerned. A wrong commit flag shows up differently: either the waveform switches before the running period ends, or a commit is never taken, so the new timing is still missing a full period after it should have appeared. A cycle-accurate model in the bench predicts every output sample. Any of these faults is therefore reported on the first cycle the pin differs, not only at the end of a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Each channel owns a 32-byte register window.
  localparam int WIN_SHIFT = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRE,
    SEL_MOD,
    SEL_DUTY,
    SEL_RUN
  } reg_sel_e;

  // Map an in-window byte offset to the register it selects.
  function automatic reg_sel_e decode_off(input logic [WIN_SHIFT-1:0] off);
    reg_sel_e sel;
    case (off)
      5'h00:   sel = SEL_PRE;
      5'h04:   sel = SEL_MOD;
      5'h08:   sel = SEL_DUTY;
      5'h18:   sel = SEL_RUN;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] load_vec,
  output logic [PRE_W-1:0]  stg_pre  [NUM_CH],
  output logic [MOD_W-1:0]  stg_mod  [NUM_CH],
  output logic [DUTY_W-1:0] stg_duty [NUM_CH],
  output logic [NUM_CH-1:0] run_vec,
  output logic [NUM_CH-1:0] pend_vec
);

  logic [CH_W-1:0]   ch_idx;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_next;

  assign ch_idx = bus_addr[ADDR_W-1:WIN_SHIFT];
  assign sel    = decode_off(bus_addr[WIN_SHIFT-1:0]);

  // Per-channel staging registers, run bit and commit flag.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (ch_idx == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        stg_pre[c]  <= '0;
        stg_mod[c]  <= '0;
        stg_duty[c] <= '0;
        run_vec[c]  <= 1'b0;
        pend_vec[c] <= 1'b0;
      end else begin
        if (hit && sel == SEL_PRE)  stg_pre[c]  <= bus_wdata[PRE_W-1:0];
        if (hit && sel == SEL_MOD)  stg_mod[c]  <= bus_wdata[MOD_W-1:0];
        if (hit && sel == SEL_DUTY) stg_duty[c] <= bus_wdata[DUTY_W-1:0];
        if (hit && sel == SEL_RUN)  run_vec[c]  <= bus_wdata[0];
        // A fresh commit wins over the load that consumes the previous one.
        if (hit && sel == SEL_DUTY) pend_vec[c] <= 1'b1;
        else if (load_vec[c])       pend_vec[c] <= 1'b0;
      end
    end
  end

  // Read multiplexer, registered.
  always_comb begin
    rd_next = '0;
    if (int'(ch_idx) < NUM_CH) begin
      case (sel)
        SEL_PRE:  rd_next[PRE_W-1:0]  = stg_pre[ch_idx];
        SEL_MOD:  rd_next[MOD_W-1:0]  = stg_mod[ch_idx];
        SEL_DUTY: rd_next[DUTY_W-1:0] = stg_duty[ch_idx];
        SEL_RUN:  rd_next[0]          = run_vec[ch_idx];
        default:  rd_next             = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pend,
  input  logic [PRE_W-1:0]  stg_pre,
  input  logic [MOD_W-1:0]  stg_mod,
  input  logic [DUTY_W-1:0] stg_duty,
  output logic              load,
  output logic              pwm
);

  localparam int CMP_W = (DUTY_W > MOD_W) ? DUTY_W : MOD_W;

  logic [PRE_W-1:0]  act_pre;
  logic [MOD_W-1:0]  act_mod;
  logic [DUTY_W-1:0] act_duty;
  logic [PRE_W-1:0]  tick_cnt;
  logic [MOD_W-1:0]  step_cnt;
  logic [MOD_W:0]    step_inc;
  logic              tick_end;
  logic              step_end;
  logic              boundary;
  logic              high_now;

  assign tick_end = (tick_cnt == act_pre);
  assign step_inc = {1'b0, step_cnt} + 1'b1;
  // A modulus of 0 or 1 both give a one-tick period.
  assign step_end = (step_inc >= {1'b0, act_mod});
  assign boundary = run && tick_end && step_end;
  assign load     = pend && (!run || boundary);
  assign high_now = run && (CMP_W'(step_cnt) < CMP_W'(act_duty));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre  <= '0;
      act_mod  <= '0;
      act_duty <= '0;
      tick_cnt <= '0;
      step_cnt <= '0;
      pwm      <= 1'b0;
    end else begin
      pwm <= high_now;
      if (load) begin
        act_pre  <= stg_pre;
        act_mod  <= stg_mod;
        act_duty <= stg_duty;
      end
      if (!run) begin
        tick_cnt <= '0;
        step_cnt <= '0;
      end else if (tick_end) begin
        tick_cnt <= '0;
        step_cnt <= step_end ? '0 : step_inc[MOD_W-1:0];
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_ctrl_top.sv
module pwm_ctrl_top
  import pwm_pkg::*;
#(
  parameter int  NUM_CH = 4,
  parameter int  DATA_W = 32,
  parameter int  PRE_W  = 8,
  parameter int  MOD_W  = 8,
  parameter int  DUTY_W = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = WIN_SHIFT + CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [PRE_W-1:0]  stg_pre  [NUM_CH];
  logic [MOD_W-1:0]  stg_mod  [NUM_CH];
  logic [DUTY_W-1:0] stg_duty [NUM_CH];
  logic [NUM_CH-1:0] run_vec;
  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] load_vec;

  pwm_regs #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .MOD_W  (MOD_W),
    .DUTY_W (DUTY_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .load_vec  (load_vec),
    .stg_pre   (stg_pre),
    .stg_mod   (stg_mod),
    .stg_duty  (stg_duty),
    .run_vec   (run_vec),
    .pend_vec  (pend_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_chan #(
      .PRE_W  (PRE_W),
      .MOD_W  (MOD_W),
      .DUTY_W (DUTY_W)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .run      (run_vec[c]),
      .pend     (pend_vec[c]),
      .stg_pre  (stg_pre[c]),
      .stg_mod  (stg_mod[c]),
      .stg_duty (stg_duty[c]),
      .load     (load_vec[c]),
      .pwm      (pwm_out[c])
    );
  end

endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] run_vec,
  input logic [NUM_CH-1:0] pend_vec
);

  localparam int CH_W = ADDR_W - WIN_SHIFT;

  reg_sel_e        sel;
  logic [CH_W-1:0] ch_idx;
  logic            rst_d;

  assign sel    = decode_off(bus_addr[WIN_SHIFT-1:0]);
  assign ch_idx = bus_addr[ADDR_W-1:WIN_SHIFT];

  // R3: an unmapped offset reads as zero on the next cycle.
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (bus_rdata == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
    // R7: a stopped channel drives low on the following cycle.
    p_stop_low_r7: assert property (@(posedge clk) disable iff (rst)
      !run_vec[c] |=> !pwm_out[c]);

    // R8: with no new write, an armed commit on a stopped channel is consumed at once.
    p_idle_flush_r8: assert property (@(posedge clk) disable iff (rst)
      (pend_vec[c] && !run_vec[c] && !bus_wr) |=> !pend_vec[c]);

    // R2: the run bit follows bit 0 of the data written to it.
    p_run_follow_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && sel == SEL_RUN && ch_idx == CH_W'(c)) |=> (run_vec[c] == $past(bus_wdata[0])));

    // R6: a duty write always leaves a commit armed.
    p_commit_arm_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && sel == SEL_DUTY && ch_idx == CH_W'(c)) |=> pend_vec[c]);
  end

  // R9: the cycle after reset releases, outputs and read data are zero.
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_quiet_r9: assert (pwm_out == '0 && bus_rdata == '0);
    end
  end

endmodule

bind pwm_ctrl_top pwm_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .run_vec   (run_vec),
  .pend_vec  (pend_vec)
);

// File: tb/pwm_ctrl_top_tb.sv
`timescale 1ns/1ps
module pwm_ctrl_top_tb;

  localparam int NUM_CH = 4;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwm_ctrl_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model: one phase counter per channel, measured in clock cycles.
  int  s_pre [NUM_CH], s_mod [NUM_CH], s_duty [NUM_CH];
  int  a_pre [NUM_CH], a_mod [NUM_CH], a_duty [NUM_CH];
  int  phase [NUM_CH];
  bit  m_run [NUM_CH], m_pend [NUM_CH];
  logic [NUM_CH-1:0] exp_q [$];

  always @(posedge clk) begin
    logic [NUM_CH-1:0] ev;
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        s_pre[c] = 0; s_mod[c] = 0; s_duty[c] = 0;
        a_pre[c] = 0; a_mod[c] = 0; a_duty[c] = 0;
        phase[c] = 0; m_run[c] = 0; m_pend[c] = 0;
      end
      exp_q.delete();
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        int plen;
        int hlen;
        bit ld;
        plen  = (a_pre[c] + 1) * ((a_mod[c] == 0) ? 1 : a_mod[c]);
        hlen  = (a_pre[c] + 1) * a_duty[c];
        ev[c] = m_run[c] && (phase[c] < hlen);
        ld    = m_pend[c] && (!m_run[c] || phase[c] == plen - 1);
        if (!m_run[c] || phase[c] == plen - 1) phase[c] = 0;
        else                                   phase[c] = phase[c] + 1;
        if (ld) begin
          a_pre[c] = s_pre[c]; a_mod[c] = s_mod[c]; a_duty[c] = s_duty[c];
          m_pend[c] = 0;
        end
      end
      if (bus_wr) begin
        int ch;
        ch = int'(bus_addr[6:5]);
        case (bus_addr[4:0])
          5'h00: s_pre[ch] = int'(bus_wdata[7:0]);
          5'h04: s_mod[ch] = int'(bus_wdata[7:0]);
          5'h08: begin s_duty[ch] = int'(bus_wdata[15:0]); m_pend[ch] = 1; end
          5'h18: m_run[ch] = bus_wdata[0];
          default: ;
        endcase
      end
      exp_q.push_back(ev);
    end
  end

  // Monitor: compare each output sample with the model (R4, R6, R7, R8, R10).
  always @(negedge clk) begin
    logic [NUM_CH-1:0] e;
    if (!rst && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk("R4,R6,R7,R8,R10 per-cycle output", 32'(pwm_out), 32'(e));
    end
  end

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = ADDR_W'(ch * 32 + off);
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(ch * 32 + off);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic measure(input int c, output int hi, output int per);
    logic prev;
    int lo;
    hi = 0; lo = 0; per = 0;
    prev = pwm_out[c];
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pwm_out[c] && !prev) break;
      prev = pwm_out[c];
    end
    hi = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pwm_out[c]) hi++; else break;
    end
    lo = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!pwm_out[c]) lo++; else break;
    end
    per = hi + lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, per, bad;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 outputs after reset", 32'(pwm_out), 32'h0);
    rd(0, 'h00, d); chk("R9 prescale after reset", d, 32'h0);
    rd(3, 'h18, d); chk("R9 run bit after reset", d, 32'h0);

    // R1 R2: readback and zero extension
    wr(0, 'h00, 32'hFFFF_FF01);
    wr(0, 'h04, 32'h0000_0004);
    rd(0, 'h00, d); chk("R2 prescale readback", d, 32'h01);
    rd(0, 'h04, d); chk("R2 modulus readback", d, 32'h04);
    wr(2, 'h08, 32'hABCD_1234);
    rd(2, 'h08, d); chk("R1 channel 2 duty readback", d, 32'h1234);

    // R3: unmapped offsets
    wr(1, 'h0C, 32'h0000_00AB);
    wr(1, 'h1C, 32'h0000_0001);
    rd(1, 'h0C, d); chk("R3 unmapped read", d, 32'h0);
    rd(1, 'h00, d); chk("R3 prescale untouched", d, 32'h0);
    rd(1, 'h18, d); chk("R3 run untouched", d, 32'h0);
    repeat (4) @(negedge clk);
    chk("R3 output stays idle", 32'(pwm_out[1]), 32'h0);

    // R4: channel 0 prescale 1, modulus 4, duty 1
    wr(0, 'h08, 32'h1);
    wr(0, 'h18, 32'h1);
    rd(0, 'h18, d); chk("R2 run readback", d, 32'h1);
    measure(0, hi, per);
    chk("R4 high time ch0", 32'(hi), 32'd2);
    chk("R4 period ch0", 32'(per), 32'd8);

    // R10: channel 1 runs its own timing
    wr(1, 'h04, 32'd5);
    wr(1, 'h08, 32'd3);
    wr(1, 'h18, 32'h1);
    measure(1, hi, per);
    chk("R10 high time ch1", 32'(hi), 32'd3);
    chk("R10 period ch1", 32'(per), 32'd5);
    measure(0, hi, per);
    chk("R10 ch0 unaffected", 32'(per), 32'd8);

    // R5: staged prescale alone has no effect
    wr(0, 'h00, 32'd3);
    repeat (10) @(negedge clk);
    measure(0, hi, per);
    chk("R5 high time unchanged", 32'(hi), 32'd2);
    chk("R5 period unchanged", 32'(per), 32'd8);

    // R6: commit applies at a period boundary
    wr(0, 'h08, 32'd2);
    measure(0, hi, per);
    chk("R6 high time after commit", 32'(hi), 32'd8);
    chk("R6 period after commit", 32'(per), 32'd16);

    // R4: duty zero and duty above modulus
    wr(1, 'h08, 32'd0);
    repeat (12) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (pwm_out[1]) bad++; end
    chk("R4 duty zero stays low", 32'(bad), 32'd0);
    wr(1, 'h08, 32'd9);
    repeat (12) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (!pwm_out[1]) bad++; end
    chk("R4 duty above modulus stays high", 32'(bad), 32'd0);

    // R7: stop in mid high phase
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (pwm_out[0]) break; end
    wr(0, 'h18, 32'h0);
    @(negedge clk);
    chk("R7 output low after stop", 32'(pwm_out[0]), 32'h0);
    rd(0, 'h18, d); chk("R7 run reads zero", d, 32'h0);

    // R8: commit while stopped, then restart from tick 0
    wr(0, 'h04, 32'd6);
    wr(0, 'h00, 32'd0);
    wr(0, 'h08, 32'd2);
    repeat (3) @(negedge clk);
    wr(0, 'h18, 32'h1);
    @(negedge clk);
    chk("R8 output rises on restart", 32'(pwm_out[0]), 32'h1);
    measure(0, hi, per);
    chk("R8 high time after idle commit", 32'(hi), 32'd2);
    chk("R8 period after idle commit", 32'(per), 32'd6);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule